// File: doc/BRIEF.md
# Quad-I/O Flash Execute-in-Place Read Sequencer

This block gives a processor a read-only, memory-mapped view of a serial flash that has already been placed in four-bit command mode. A request carries an address and a read/write flag. For a read, the block lowers chip select and sends the command byte as two nibbles. It then sends the address as 5 to 8 nibbles. The order of command and address is selectable. The block releases the data lines for a programmable number of dummy clocks, collects eight nibbles, and returns them as one 32-bit word.

The sequencer clock runs at twice the base clock. Each half of an SCK period lasts (divider + 3) sequencer cycles, so the SCK period is (divider + 3) base-clock periods and the high and low phases are equal for any divider. Between two accesses, chip select stays high for a programmable number of SCK periods. SCK stays low while the flash is not selected.

Three faults are flagged, each held until software writes a 1 to clear it: a write into the window, a read while the function is off, and a serial clock that does not move. A faulting access completes at once with read data 0, and a single-cycle interrupt pulse marks each new fault. After a clock timeout the sequencer locks until the enable is dropped.

Top module: `xip_quad_reader`

## Requirements
- R1: With `cfg_addr_first`=0 the two command nibbles are sent before the address; with 1 the address nibbles come first. The command's upper nibble is always sent before its lower one.
- R2: `cfg_addr_nib` codes 0..3 send 5, 6, 7 or 8 address nibbles, most significant nibble first. The nibbles are the low bits of the masked address.
- R3: `cfg_addr_width` codes 0..6 keep the low 20..26 address bits and clear the rest. The reserved code 7 behaves as 26 bits.
- R4: After the header come exactly `cfg_dummy` (0..15) SCK periods with `sio_oe`=0. These are followed by 8 data periods, also with `sio_oe`=0. During command and address `sio_oe`=4'hF.
- R5: Data nibble k (0..7) is sampled on the k-th data rising edge. Byte k/2 of `rsp_data` (bits 8*(k/2)+7 down to 8*(k/2)) receives it: the upper half when k is even, the lower half when k is odd. The word comes back with `rsp_valid` high and `rsp_err`=0.
- R6: SCK idles low. Each SCK phase lasts `cfg_div`+3 `clk` cycles, so the high time equals the low time, including for odd sums. SCK is low whenever `flash_cs_n` is high.
- R7: After a read, `flash_cs_n` stays high and `req_ready` stays low for at least 2*(`cfg_div`+3)*(`cfg_cs_idle`+1) `clk` cycles before the next access may select the flash.
- R8: An accepted request with `req_write`=1 sets `err_flags[0]` and answers with `rsp_err`=1 and `rsp_data`=0. The flash is not selected.
- R9: An accepted read with `cfg_enable`=0 sets `err_flags[1]` and answers with `rsp_err`=1 and `rsp_data`=0. The flash is not selected.
- R10: During a transfer, if `sck_fb` stays unchanged for `TMO_LIMIT` cycles, the block sets `err_flags[2]`, raises `flash_cs_n`, and answers with `rsp_err`=1 and data 0. It then holds `req_ready` low until `cfg_enable` is driven to 0.
- R11: A 1 in bit i of `err_clear` clears `err_flags[i]`; a new fault in the same cycle wins. Each fault pulses `err_irq` for exactly one cycle, together with its error response.
- R12: After reset, `flash_cs_n`=1, `flash_sck`=0, `sio_oe`=0, `req_ready`=1, `err_flags`=0 and `err_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Function enable |
| cfg_addr_first | input | 1 | 1: address before command |
| cfg_addr_nib | input | 2 | Address nibble count code (5 + code) |
| cfg_addr_width | input | 3 | Address width code (20 + code bits) |
| cfg_cmd | input | 8 | Read command byte |
| cfg_dummy | input | 4 | Dummy SCK periods |
| cfg_cs_idle | input | 2 | Chip-select high time minus one, in SCK periods |
| cfg_div | input | 8 | Clock divider; SCK phase = div + 3 cycles |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Access address |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_data | output | 32 | Read word, 0 on fault |
| rsp_err | output | 1 | Access faulted |
| err_clear | input | 3 | Write-1-to-clear for err_flags |
| err_flags | output | 3 | {timeout, disabled, write} fault flags |
| err_irq | output | 1 | Fault interrupt pulse |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Serial clock |
| sio_out | output | 4 | Data line output values |
| sio_oe | output | 4 | Data line output enables |
| sio_in | input | 4 | Data line input values |
| sck_fb | input | 1 | Serial clock pad readback |

## Verification
A bench flash model records every nibble and its enable on each SCK rising edge, and drives read nibbles on falling edges. This exposes a swapped command/address order, a nibble-order slip, or an address mask one bit off. It also exposes a dummy count off by one: that would shift every data nibble and garble the returned word. Reads are repeated with the smallest and largest nibble counts, the reserved width code, zero and fifteen dummies, and odd and even divider sums. These catch a period or duty-cycle error, a truncated address, and a miscounted hold time between back-to-back reads. The fault paths check that a write or a disabled read never touches chip select. They also check that a stuck clock locks the sequencer until the enable drops, and that clearing one flag leaves the others intact.

// File: rtl/xip_quad_reader.sv
module xip_quad_reader #(
  parameter int TMO_LIMIT = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_enable,
  input  logic        cfg_addr_first,
  input  logic [1:0]  cfg_addr_nib,
  input  logic [2:0]  cfg_addr_width,
  input  logic [7:0]  cfg_cmd,
  input  logic [3:0]  cfg_dummy,
  input  logic [1:0]  cfg_cs_idle,
  input  logic [7:0]  cfg_div,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_err,
  input  logic [2:0]  err_clear,
  output logic [2:0]  err_flags,
  output logic        err_irq,
  output logic        flash_cs_n,
  output logic        flash_sck,
  output logic [3:0]  sio_out,
  output logic [3:0]  sio_oe,
  input  logic [3:0]  sio_in,
  input  logic        sck_fb
);

  localparam int TW = $clog2(TMO_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_HOLD, S_LOCK} state_t;

  state_t      state;
  logic [31:0] a_r, word;
  logic [5:0]  slot;
  logic [8:0]  ph;
  logic [11:0] hcnt;
  logic [TW-1:0] tmo;
  logic        fb_q;

  logic [8:0]  half;
  logic [11:0] hold_len;
  logic [4:0]  aw;
  logic [31:0] amask;
  logic [5:0]  nib_n, hdr_n, dstart, last_slot, ai, sh;
  logic        in_addr, ci_lo, drive, accept, tmo_hit;
  logic [3:0]  addr_nib, cmd_nib;
  logic [2:0]  kidx;
  logic [4:0]  dbase;
  logic [2:0]  new_err;

  assign half      = {1'b0, cfg_div} + 9'd3;
  assign hold_len  = {2'b0, half, 1'b0} * {9'b0, ({1'b0, cfg_cs_idle} + 3'd1)};
  assign aw        = (cfg_addr_width == 3'd7) ? 5'd26 : 5'd20 + {2'b0, cfg_addr_width};
  assign amask     = (32'h1 << aw) - 32'h1;
  assign nib_n     = 6'd5 + {4'b0, cfg_addr_nib};
  assign hdr_n     = nib_n + 6'd2;
  assign dstart    = hdr_n + {2'b0, cfg_dummy};
  assign last_slot = dstart + 6'd7;

  always_comb begin
    if (cfg_addr_first) begin
      in_addr = slot < nib_n;
      ai      = slot;
      ci_lo   = slot[0] ^ nib_n[0];
    end else begin
      in_addr = (slot >= 6'd2) && (slot < hdr_n);
      ai      = slot - 6'd2;
      ci_lo   = slot[0];
    end
  end

  assign sh       = (nib_n - 6'd1 - ai) << 2;
  assign addr_nib = 4'(a_r >> sh);
  assign cmd_nib  = ci_lo ? cfg_cmd[3:0] : cfg_cmd[7:4];
  assign drive    = (state == S_XFER) && (slot < hdr_n);
  assign sio_out  = drive ? (in_addr ? addr_nib : cmd_nib) : 4'h0;
  assign sio_oe   = drive ? 4'hF : 4'h0;

  assign kidx   = 3'(slot - dstart);
  assign dbase  = {kidx[2:1], ~kidx[0], 2'b00};

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign tmo_hit   = (state == S_XFER) && (sck_fb == fb_q) && (tmo == TW'(TMO_LIMIT - 1));
  assign new_err   = {tmo_hit, accept && !req_write && !cfg_enable, accept && req_write};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_irq   <= 1'b0;
      fb_q      <= 1'b0;
    end else begin
      err_flags <= (err_flags & ~err_clear) | new_err;
      err_irq   <= |new_err;
      fb_q      <= sck_fb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      a_r        <= '0;
      word       <= '0;
      slot       <= '0;
      ph         <= '0;
      hcnt       <= '0;
      tmo        <= '0;
      flash_cs_n <= 1'b1;
      flash_sck  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (req_write || !cfg_enable) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_data  <= '0;
          end else begin
            a_r        <= req_addr & amask;
            word       <= '0;
            slot       <= '0;
            ph         <= '0;
            tmo        <= '0;
            flash_cs_n <= 1'b0;
            flash_sck  <= 1'b0;
            state      <= S_XFER;
          end
        end
        S_XFER: begin
          tmo <= (sck_fb != fb_q) ? '0 : tmo + 1'b1;
          if (tmo_hit) begin
            flash_cs_n <= 1'b1;
            flash_sck  <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_err    <= 1'b1;
            rsp_data   <= '0;
            state      <= S_LOCK;
          end else if (ph == half - 9'd1) begin
            ph <= '0;
            if (!flash_sck) begin
              flash_sck <= 1'b1;
              if (slot >= dstart) word[dbase +: 4] <= sio_in;
            end else begin
              flash_sck <= 1'b0;
              if (slot == last_slot) begin
                flash_cs_n <= 1'b1;
                rsp_valid  <= 1'b1;
                rsp_err    <= 1'b0;
                rsp_data   <= word;
                hcnt       <= '0;
                state      <= S_HOLD;
              end else begin
                slot <= slot + 6'd1;
              end
            end
          end else begin
            ph <= ph + 9'd1;
          end
        end
        S_HOLD: begin
          hcnt <= hcnt + 12'd1;
          if (hcnt == hold_len - 12'd1) state <= S_IDLE;
        end
        default: if (!cfg_enable) state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xip_quad_reader_chk.sv
module xip_quad_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_enable,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        rsp_err,
  input logic [2:0]  err_flags,
  input logic        err_irq,
  input logic        flash_cs_n,
  input logic        flash_sck,
  input logic [3:0]  sio_oe
);

  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck); // R6

  AST_WRITE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (flash_cs_n && err_flags[0])); // R8

  AST_DISABLED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !cfg_enable) |=> (flash_cs_n && err_flags[1])); // R9

  AST_FAULT_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == 32'h0)); // R11

  AST_IRQ_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (rsp_valid && rsp_err)); // R11

  AST_CS_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_cs_n) |=> (flash_cs_n && !req_ready)); // R7

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> (sio_oe == 4'h0)); // R4

endmodule

bind xip_quad_reader xip_quad_reader_chk u_chk (.*);

// File: tb/tb_xip_quad_reader.sv
module tb_xip_quad_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1, cfg_addr_first = 1'b0;
  logic [1:0]  cfg_addr_nib = 2'd1;
  logic [2:0]  cfg_addr_width = 3'd4;
  logic [7:0]  cfg_cmd = 8'hEB;
  logic [3:0]  cfg_dummy = 4'd2;
  logic [1:0]  cfg_cs_idle = 2'd0;
  logic [7:0]  cfg_div = 8'd2;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_err, err_irq, flash_cs_n, flash_sck, sck_fb;
  logic [31:0] rsp_data;
  logic [2:0]  err_clear = '0, err_flags;
  logic [3:0]  sio_out, sio_oe;
  logic [3:0]  sio_in = '0;
  logic        stuck = 1'b0;

  int checks = 0, fails = 0, cyc = 0, irq_cnt = 0, cs_falls = 0;
  int idx = 0, fl_dstart = 100, cs_rise_t = 0, cs_fall_t = 0;
  logic [31:0] fl_word = '0;
  logic [3:0]  cap [64];
  logic [3:0]  oecap [64];
  int          rise_t [64];
  int          fall_t [64];
  logic [31:0] got_data;
  logic        got_err;
  bit          done = 0;

  assign sck_fb = stuck ? 1'b0 : flash_sck;

  xip_quad_reader #(.TMO_LIMIT(96)) dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) begin
    cyc++;
    if (err_irq) irq_cnt++;
  end

  always @(negedge flash_cs_n) begin idx = 0; cs_falls++; cs_fall_t = cyc; end
  always @(posedge flash_cs_n) cs_rise_t = cyc;
  always @(posedge flash_sck) if (idx < 64) begin
    cap[idx] = sio_out; oecap[idx] = sio_oe; rise_t[idx] = cyc; idx++;
  end
  always @(negedge flash_sck) begin
    int k;
    if (idx > 0 && idx <= 64) fall_t[idx-1] = cyc;
    k = idx - fl_dstart;
    if (k >= 0 && k < 8) sio_in = fl_word[8*(k/2) + ((k % 2) ? 0 : 4) +: 4];
    else sio_in = 4'h0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    while (!rsp_valid) @(negedge clk);
    got_data = rsp_data;
    got_err  = rsp_err;
  endtask

  task automatic t_read(input bit afirst, input logic [1:0] nc, input logic [2:0] wc,
                        input logic [3:0] dm, input logic [7:0] dv, input logic [7:0] cmd,
                        input logic [31:0] addr, input logic [31:0] w);
    int n, wbits, hdr, bad_ord, bad_oe;
    longint am;
    logic [3:0] e;
    logic [31:0] got_a;
    @(negedge clk);
    cfg_addr_first = afirst; cfg_addr_nib = nc; cfg_addr_width = wc;
    cfg_dummy = dm; cfg_div = dv; cfg_cmd = cmd;
    n = 5 + nc; hdr = n + 2;
    wbits = (wc == 3'd7) ? 26 : 20 + wc;
    am = longint'(addr) & ((64'd1 << wbits) - 1);
    am = am & ((64'd1 << (4*n)) - 1);
    fl_word = w; fl_dstart = hdr + dm;
    do_req(1'b0, addr);
    wait_rsp();
    chk(got_err == 1'b0 && got_data == w, "R5 read word", got_data, w);
    chk(idx == hdr + dm + 8, "R4 rising edge count", idx, hdr + dm + 8);
    bad_ord = 0; got_a = '0;
    for (int i = 0; i < hdr; i++) begin
      int ai;
      ai = afirst ? i : i - 2;
      if (ai >= 0 && ai < n) begin
        e = 4'(am >> (4*(n-1-ai)));
        got_a = {got_a[27:0], cap[i]};
      end else begin
        e = ((afirst ? i - n : i) == 0) ? cmd[7:4] : cmd[3:0];
      end
      if (cap[i] !== e) bad_ord++;
    end
    chk(bad_ord == 0, afirst ? "R1 address-first header" : "R1 command-first header", bad_ord, 0);
    chk(got_a == 32'(am), "R2 R3 address nibbles", got_a, 32'(am));
    bad_oe = 0;
    for (int i = 0; i < hdr + dm + 8; i++)
      if (oecap[i] !== ((i < hdr) ? 4'hF : 4'h0)) bad_oe++;
    chk(bad_oe == 0, "R4 output enable per period", bad_oe, 0);
    chk(rise_t[1] - rise_t[0] == 2*(dv + 3), "R6 SCK period", rise_t[1] - rise_t[0], 2*(dv + 3));
    chk(fall_t[0] - rise_t[0] == dv + 3, "R6 SCK high time", fall_t[0] - rise_t[0], dv + 3);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(flash_cs_n == 1'b1 && flash_sck == 1'b0 && sio_oe == 4'h0, "R12 pins idle",
        {flash_cs_n, flash_sck, sio_oe}, 6'b100000);
    chk(req_ready == 1'b1 && err_flags == 3'b0 && err_irq == 1'b0, "R12 ready and flags",
        {req_ready, err_flags, err_irq}, 5'b10000);
  endtask

  task automatic t_hold();
    int hold;
    @(negedge clk);
    cfg_cs_idle = 2'd3; cfg_div = 8'd2; cfg_addr_first = 0; cfg_addr_nib = 2'd1; cfg_dummy = 4'd2;
    fl_word = 32'h1234_5678; fl_dstart = 10;
    hold = 2*5*4;
    do_req(1'b0, 32'h100);
    wait_rsp();
    chk(req_ready == 1'b0, "R7 ready low after read", req_ready, 0);
    do_req(1'b0, 32'h200);
    chk(cs_fall_t - cs_rise_t >= hold && cs_fall_t - cs_rise_t <= hold + 1, "R7 chip-select high time",
        cs_fall_t - cs_rise_t, hold);
    wait_rsp();
    chk(got_data == 32'h1234_5678, "R7 second read data", got_data, 32'h1234_5678);
    cfg_cs_idle = 2'd0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_write();
    int c0, i0;
    c0 = cs_falls; i0 = irq_cnt;
    do_req(1'b1, 32'h40);
    wait_rsp();
    chk(got_err == 1'b1 && got_data == 32'h0, "R8 write error response", {got_err, got_data}, 33'h1_0000_0000);
    @(negedge clk);
    chk(err_flags == 3'b001, "R8 write flag", err_flags, 3'b001);
    chk(cs_falls == c0, "R8 flash not selected", cs_falls, c0);
    chk(irq_cnt == i0 + 1, "R11 irq pulse on write fault", irq_cnt, i0 + 1);
  endtask

  task automatic t_disabled();
    int c0;
    c0 = cs_falls;
    @(negedge clk); cfg_enable = 1'b0;
    do_req(1'b0, 32'h80);
    wait_rsp();
    chk(got_err == 1'b1 && got_data == 32'h0, "R9 disabled response", {got_err, got_data}, 33'h1_0000_0000);
    @(negedge clk);
    chk(err_flags == 3'b011, "R9 disabled flag", err_flags, 3'b011);
    chk(cs_falls == c0, "R9 flash not selected", cs_falls, c0);
    cfg_enable = 1'b1;
  endtask

  task automatic t_clear();
    @(negedge clk); err_clear = 3'b001;
    @(negedge clk); err_clear = 3'b000;
    chk(err_flags == 3'b010, "R11 clear one flag", err_flags, 3'b010);
    @(negedge clk); err_clear = 3'b111;
    @(negedge clk); err_clear = 3'b000;
    chk(err_flags == 3'b000, "R11 clear all flags", err_flags, 3'b000);
  endtask

  task automatic t_timeout();
    int i0;
    i0 = irq_cnt;
    @(negedge clk);
    cfg_div = 8'd2; cfg_dummy = 4'd2; cfg_addr_nib = 2'd1; stuck = 1'b1;
    do_req(1'b0, 32'h300);
    wait_rsp();
    chk(got_err == 1'b1 && got_data == 32'h0, "R10 timeout response", {got_err, got_data}, 33'h1_0000_0000);
    repeat (3) @(negedge clk);
    chk(err_flags == 3'b100, "R10 timeout flag", err_flags, 3'b100);
    chk(flash_cs_n == 1'b1 && req_ready == 1'b0, "R10 locked and deselected", {flash_cs_n, req_ready}, 2'b10);
    chk(irq_cnt == i0 + 1, "R11 irq pulse on timeout", irq_cnt, i0 + 1);
    stuck = 1'b0; cfg_enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R10 unlock by disable", req_ready, 1);
    cfg_enable = 1'b1; err_clear = 3'b111;
    @(negedge clk); err_clear = 3'b000;
    t_read(1'b0, 2'd1, 3'd4, 4'd2, 8'd2, 8'hEB, 32'h00AB_CDEF, 32'h0F1E_2D3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read(1'b0, 2'd1, 3'd4, 4'd2, 8'd2, 8'hEB, 32'h12AB_CDEF, 32'hDEAD_BEEF);
    t_read(1'b1, 2'd3, 3'd6, 4'd0, 8'd2, 8'h0B, 32'hF765_4321, 32'h8765_4321);
    t_read(1'b0, 2'd0, 3'd0, 4'd15, 8'd0, 8'h6B, 32'hFFFF_FFFF, 32'hA5C3_0F96);
    t_read(1'b1, 2'd3, 3'd7, 4'd1, 8'd5, 8'hE7, 32'hFFFF_FFFF, 32'h0123_4567);
    t_read(1'b0, 2'd2, 3'd2, 4'd3, 8'd1, 8'h3C, 32'h00C9_8765, 32'h55AA_33CC);
    t_hold();
    t_write();
    t_disabled();
    t_clear();
    t_timeout();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule